// File: doc/BRIEF.md
# Low-Power Wait and Stop Sequencer

This block sequences standby for a small 8-bit CPU core. The instruction decoder sends it a one-cycle strobe when it executes a wait or a stop instruction. The block then drops the CPU clock enable. For a stop it also drops the peripheral clock enable. On entry it clears the interrupt mask bit. While the core idles, it watches the enabled interrupt requests and the break request. When one of them arrives, it raises a one-cycle wake pulse and returns the core to normal execution. For an interrupt wake it also raises a one-cycle strobe that starts interrupt stacking in the cycle after the interrupt was seen.

The controller has four states:
- `ST_RUN`: normal execution.
- `ST_WAIT`: CPU unclocked, peripherals clocked.
- `ST_STOP`: both clock enables low.
- `ST_WAKE`: a single cycle that carries the wake pulse.

It has these transitions:
- RUN to WAIT on a wait strobe.
- RUN to STOP on a stop strobe.
- RUN to WAKE when a wake source is already present in the cycle of the strobe.
- WAIT to WAKE on a break or any enabled interrupt.
- STOP to WAKE on a break or an enabled interrupt on a line marked external.
- WAKE to RUN always.

An active-low asynchronous reset ends either idle state and takes priority over everything else. Break takes priority over an interrupt.

A break that ends an idle state sets a status flag. Software reads the flag through a one-register port and clears it by writing 0. The block also drives the watchdog enable from an option input.

Top module: `standby_seq`

## Requirements
- R1: After reset, cpu_clk_en and per_clk_en are 1. imask_clr, wake_pulse and stack_go are 0. wake_cause is 2'b00. reg_rdata is 0.
- R2: A wait_req in ST_RUN, with stop_req low and no wake source present, gives cpu_clk_en=0 and per_clk_en=1 from the next cycle until a wake.
- R3: A stop_req in ST_RUN, with no break and no enabled external interrupt present, gives cpu_clk_en=0 and per_clk_en=0 from the next cycle. When wait_req and stop_req arrive together, stop wins.
- R4: A wait_req or stop_req accepted in ST_RUN raises imask_clr for exactly the next cycle.
- R5: In ST_WAIT, any line with irq_req[i]=1 and irq_en[i]=1 and brk_req low leads to a wake in the next cycle. In that cycle wake_pulse=1, stack_go=1 and wake_cause=2'b01. The following cycle is ST_RUN.
- R6: An interrupt line whose irq_en bit is 0 has no effect. It does not end ST_WAIT or ST_STOP.
- R7: ST_STOP ends only on a break or on an enabled interrupt on a line whose bit in EXT_MASK is 1 (default 8'h03, lines 0 and 1). An enabled non-external line leaves per_clk_en at 0.
- R8: brk_req during ST_WAIT or ST_STOP, or together with an accepted strobe, leads to a wake in the next cycle. In that cycle wake_pulse=1, stack_go=0 and wake_cause=2'b10, and the break status flag (reg_rdata bit FLAG_BIT=1) reads 1.
- R9: When brk_req and an enabled interrupt are present in the same idle cycle, the break wins (wake_cause=2'b10, stack_go=0).
- R10: reg_wr with reg_wbit=0 clears the break flag. reg_wr with reg_wbit=1 has no effect. A break set in the same cycle wins over a clear. All reg_rdata bits other than FLAG_BIT read 0.
- R11: wdog_en is 1 exactly when wdog_dis=0 and the controller is not in ST_STOP. It stays 1 in ST_WAIT.
- R12: wait_req and stop_req are ignored in ST_WAIT, ST_STOP and ST_WAKE. The wake state always lasts exactly one cycle and is followed by ST_RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_req | input | 1 | One-cycle wait strobe from the decoder |
| stop_req | input | 1 | One-cycle stop strobe from the decoder |
| irq_req | input | NUM_IRQ | Interrupt request lines |
| irq_en | input | NUM_IRQ | Per-line interrupt enables |
| brk_req | input | 1 | Break request |
| wdog_dis | input | 1 | Watchdog disable option bit |
| reg_wr | input | 1 | Status register write strobe |
| reg_wbit | input | 1 | Value written to the break flag (0 clears) |
| reg_rdata | output | REG_W | Status register read value |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| imask_clr | output | 1 | One-cycle pulse clearing the interrupt mask bit |
| wake_pulse | output | 1 | One-cycle wake indication to the CPU |
| stack_go | output | 1 | One-cycle strobe starting interrupt stacking |
| wake_cause | output | 2 | 01 interrupt, 10 break, 00 otherwise |
| wdog_en | output | 1 | Watchdog enable |

## Verification
The assertions assume that the decoder issues wait_req and stop_req only while the CPU is clocked. They also assume that interrupt and break inputs are synchronous to clk and stable around the edge. The bench drives all inputs on the falling edge. It raises strobes only while the reference model is in the run state, except in the cases that deliberately check that strobes in other states are ignored. A behavioural model in the bench tracks the expected mode, wake cause and flag. The bench compares every output against that model on every cycle.

// File: rtl/standby_pkg.sv
package standby_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_WAIT = 2'd1,
        ST_STOP = 2'd2,
        ST_WAKE = 2'd3
    } sb_state_e;

    typedef enum logic [1:0] {
        WK_NONE = 2'b00,
        WK_IRQ  = 2'b01,
        WK_BRK  = 2'b10
    } wake_cause_e;

endpackage

// File: rtl/wake_detect.sv
module wake_detect #(
    parameter int                 NUM_IRQ  = 8,
    parameter logic [NUM_IRQ-1:0] EXT_MASK = 8'h03
) (
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_en,
    output logic               any_hit,
    output logic               ext_hit
);
    logic [NUM_IRQ-1:0] hit;
    logic [NUM_IRQ-1:0] ext;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        assign hit[i] = irq_req[i] & irq_en[i];
        if (EXT_MASK[i]) begin : g_ext
            assign ext[i] = hit[i];
        end else begin : g_int
            assign ext[i] = 1'b0;
        end
    end

    assign any_hit = |hit;
    assign ext_hit = |ext;
endmodule

// File: rtl/brk_status_reg.sv
module brk_status_reg #(
    parameter int REG_W    = 8,
    parameter int FLAG_BIT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic             wr_i,
    input  logic             wbit_i,
    output logic [REG_W-1:0] rdata_o
);
    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (wr_i && !wbit_i) begin
            flag_q <= 1'b0;
        end
    end

    always_comb begin
        rdata_o           = '0;
        rdata_o[FLAG_BIT] = flag_q;
    end
endmodule

// File: rtl/standby_seq.sv
module standby_seq
    import standby_pkg::*;
#(
    parameter int                 NUM_IRQ  = 8,
    parameter logic [NUM_IRQ-1:0] EXT_MASK = 8'h03,
    parameter int                 REG_W    = 8,
    parameter int                 FLAG_BIT = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wait_req,
    input  logic               stop_req,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               brk_req,
    input  logic               wdog_dis,
    input  logic               reg_wr,
    input  logic               reg_wbit,
    output logic [REG_W-1:0]   reg_rdata,
    output logic               cpu_clk_en,
    output logic               per_clk_en,
    output logic               imask_clr,
    output logic               wake_pulse,
    output logic               stack_go,
    output logic [1:0]         wake_cause,
    output logic               wdog_en
);
    sb_state_e   state_q, state_d;
    wake_cause_e cause_q, cause_d;
    logic        imask_q, imask_d;
    logic        any_hit, ext_hit;
    logic        brk_set;

    wake_detect #(
        .NUM_IRQ  (NUM_IRQ),
        .EXT_MASK (EXT_MASK)
    ) u_wake (
        .irq_req (irq_req),
        .irq_en  (irq_en),
        .any_hit (any_hit),
        .ext_hit (ext_hit)
    );

    brk_status_reg #(
        .REG_W    (REG_W),
        .FLAG_BIT (FLAG_BIT)
    ) u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (brk_set),
        .wr_i    (reg_wr),
        .wbit_i  (reg_wbit),
        .rdata_o (reg_rdata)
    );

    // Next-state and wake-cause selection; break outranks interrupts.
    always_comb begin
        state_d = state_q;
        cause_d = cause_q;
        imask_d = 1'b0;
        brk_set = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (stop_req) begin
                    imask_d = 1'b1;
                    if (brk_req) begin
                        state_d = ST_WAKE;
                        cause_d = WK_BRK;
                        brk_set = 1'b1;
                    end else if (ext_hit) begin
                        state_d = ST_WAKE;
                        cause_d = WK_IRQ;
                    end else begin
                        state_d = ST_STOP;
                    end
                end else if (wait_req) begin
                    imask_d = 1'b1;
                    if (brk_req) begin
                        state_d = ST_WAKE;
                        cause_d = WK_BRK;
                        brk_set = 1'b1;
                    end else if (any_hit) begin
                        state_d = ST_WAKE;
                        cause_d = WK_IRQ;
                    end else begin
                        state_d = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (brk_req) begin
                    state_d = ST_WAKE;
                    cause_d = WK_BRK;
                    brk_set = 1'b1;
                end else if (any_hit) begin
                    state_d = ST_WAKE;
                    cause_d = WK_IRQ;
                end
            end
            ST_STOP: begin
                if (brk_req) begin
                    state_d = ST_WAKE;
                    cause_d = WK_BRK;
                    brk_set = 1'b1;
                end else if (ext_hit) begin
                    state_d = ST_WAKE;
                    cause_d = WK_IRQ;
                end
            end
            ST_WAKE: begin
                state_d = ST_RUN;
                cause_d = WK_NONE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cause_q <= WK_NONE;
            imask_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
            imask_q <= imask_d;
        end
    end

    // Moore outputs decoded from the state register.
    always_comb begin
        cpu_clk_en = 1'b1;
        per_clk_en = 1'b1;
        wake_pulse = 1'b0;
        stack_go   = 1'b0;
        wake_cause = WK_NONE;
        unique case (state_q)
            ST_RUN: ;
            ST_WAIT: cpu_clk_en = 1'b0;
            ST_STOP: begin
                cpu_clk_en = 1'b0;
                per_clk_en = 1'b0;
            end
            ST_WAKE: begin
                wake_pulse = 1'b1;
                stack_go   = (cause_q == WK_IRQ);
                wake_cause = cause_q;
            end
        endcase
        imask_clr = imask_q;
        wdog_en   = !wdog_dis && (state_q != ST_STOP);
    end
endmodule

module standby_seq_chk #(
    parameter int                 NUM_IRQ  = 8,
    parameter logic [NUM_IRQ-1:0] EXT_MASK = 8'h03,
    parameter int                 REG_W    = 8,
    parameter int                 FLAG_BIT = 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wait_req,
    input logic               stop_req,
    input logic [NUM_IRQ-1:0] irq_req,
    input logic [NUM_IRQ-1:0] irq_en,
    input logic               brk_req,
    input logic               wdog_dis,
    input logic [REG_W-1:0]   reg_rdata,
    input logic               cpu_clk_en,
    input logic               per_clk_en,
    input logic               imask_clr,
    input logic               wake_pulse,
    input logic               stack_go,
    input logic [1:0]         wake_cause,
    input logic               wdog_en
);
    localparam logic [REG_W-1:0] FLAG_MASK = REG_W'(1) << FLAG_BIT;

    logic run, any_en, ext_en;
    assign run    = cpu_clk_en && !wake_pulse;
    assign any_en = |(irq_req & irq_en);
    assign ext_en = |(irq_req & irq_en & EXT_MASK);

    AST_WAIT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        run && wait_req && !stop_req && !brk_req && !any_en |=> !cpu_clk_en && per_clk_en); // R2
    AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        run && stop_req && !brk_req && !ext_en |=> !cpu_clk_en && !per_clk_en); // R3
    AST_IMASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        run && (wait_req || stop_req) |=> imask_clr); // R4
    AST_IMASK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        imask_clr |=> !imask_clr); // R4
    AST_WAIT_IRQ_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_clk_en && per_clk_en && !brk_req && any_en |=> wake_pulse && stack_go); // R5
    AST_MASKED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_clk_en && per_clk_en && !brk_req && !any_en |=> !cpu_clk_en); // R6
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !per_clk_en && !brk_req && !ext_en |=> !per_clk_en); // R7
    AST_BRK_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_clk_en && brk_req |=> wake_pulse && !stack_go && wake_cause == 2'b10 && reg_rdata[FLAG_BIT]); // R8 R9
    AST_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~FLAG_MASK) == '0); // R10
    AST_WDOG_EN: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_en == (per_clk_en && !wdog_dis)); // R11
    AST_WAKE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> cpu_clk_en && !wake_pulse); // R12
endmodule

bind standby_seq standby_seq_chk #(
    .NUM_IRQ  (NUM_IRQ),
    .EXT_MASK (EXT_MASK),
    .REG_W    (REG_W),
    .FLAG_BIT (FLAG_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wait_req   (wait_req),
    .stop_req   (stop_req),
    .irq_req    (irq_req),
    .irq_en     (irq_en),
    .brk_req    (brk_req),
    .wdog_dis   (wdog_dis),
    .reg_rdata  (reg_rdata),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .imask_clr  (imask_clr),
    .wake_pulse (wake_pulse),
    .stack_go   (stack_go),
    .wake_cause (wake_cause),
    .wdog_en    (wdog_en)
);

// File: tb/sim_standby_seq.sv
`timescale 1ns/1ps
module sim_standby_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wait_req = 0, stop_req = 0, brk_req = 0, wdog_dis = 0;
    logic       reg_wr = 0, reg_wbit = 0;
    logic [7:0] irq_req = '0, irq_en = '0;
    logic [7:0] reg_rdata;
    logic       cpu_clk_en, per_clk_en, imask_clr, wake_pulse, stack_go, wdog_en;
    logic [1:0] wake_cause;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    standby_seq u0 (
        .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .stop_req(stop_req),
        .irq_req(irq_req), .irq_en(irq_en), .brk_req(brk_req), .wdog_dis(wdog_dis),
        .reg_wr(reg_wr), .reg_wbit(reg_wbit), .reg_rdata(reg_rdata),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .imask_clr(imask_clr),
        .wake_pulse(wake_pulse), .stack_go(stack_go), .wake_cause(wake_cause),
        .wdog_en(wdog_en)
    );

    always #5 clk = ~clk;

    // Reference model: mode 0 run, 1 wait, 2 stop, 3 wake.
    int m_mode = 0, m_cause = 0, m_imask = 0, m_flag = 0;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_cause = 0; m_imask = 0; m_flag = 0;
        end else begin
            int  nm, nc, ni, nf;
            bit  anyi, exti;
            anyi = (irq_req & irq_en) != 0;
            exti = (irq_req & irq_en & 8'h03) != 0;
            nm = m_mode; nc = m_cause; ni = 0; nf = m_flag;
            if (reg_wr && !reg_wbit) nf = 0;
            if (m_mode == 0 && (wait_req || stop_req)) begin
                ni = 1;
                if (brk_req) begin nm = 3; nc = 2; nf = 1; end
                else if (stop_req ? exti : anyi) begin nm = 3; nc = 1; end
                else nm = stop_req ? 2 : 1;
            end else if (m_mode == 1 || m_mode == 2) begin
                if (brk_req) begin nm = 3; nc = 2; nf = 1; end
                else if (m_mode == 1 ? anyi : exti) begin nm = 3; nc = 1; end
            end else if (m_mode == 3) begin
                nm = 0; nc = 0;
            end
            m_mode = nm; m_cause = nc; m_imask = ni; m_flag = nf;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int e_cpu, e_per, e_wake, e_stk, e_cause, e_rd, e_wd;
        e_cpu   = (m_mode == 0 || m_mode == 3);
        e_per   = (m_mode != 2);
        e_wake  = (m_mode == 3);
        e_stk   = (m_mode == 3 && m_cause == 1);
        e_cause = (m_mode == 3) ? m_cause : 0;
        e_rd    = m_flag << 1;
        e_wd    = (!wdog_dis && m_mode != 2);
        chk(cpu_clk_en == e_cpu, "R2 cpu_clk_en", cpu_clk_en, e_cpu);
        chk(per_clk_en == e_per, "R3 per_clk_en", per_clk_en, e_per);
        chk(imask_clr == m_imask, "R4 imask_clr", imask_clr, m_imask);
        chk(wake_pulse == e_wake, "R5 wake_pulse", wake_pulse, e_wake);
        chk(stack_go == e_stk, "R5 stack_go", stack_go, e_stk);
        chk(wake_cause == e_cause, "R9 wake_cause", wake_cause, e_cause);
        chk(reg_rdata == e_rd, "R10 reg_rdata", reg_rdata, e_rd);
        chk(wdog_en == e_wd, "R11 wdog_en", wdog_en, e_wd);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic strobe_wait();
        wait_req = 1; tick(); wait_req = 0;
    endtask

    task automatic strobe_stop();
        stop_req = 1; tick(); stop_req = 0;
    endtask

    initial begin
        #20000000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R1 reset state
        chk(cpu_clk_en && per_clk_en && !imask_clr && !wake_pulse && !stack_go
            && wake_cause == 0 && reg_rdata == 0, "R1 reset state",
            {cpu_clk_en, per_clk_en, imask_clr, wake_pulse, stack_go}, 5'b11000);
        rst_n = 1;
        ticks(2);

        // Wait then enabled interrupt on line 3
        irq_en = 8'h08;
        strobe_wait();
        chk(!cpu_clk_en && per_clk_en, "R2 wait clocks", cpu_clk_en, 0);
        ticks(3);
        irq_req = 8'h08; tick(); irq_req = 0;
        chk(stack_go && wake_cause == 2'b01, "R5 irq wake", stack_go, 1);
        tick();
        chk(cpu_clk_en && !wake_pulse, "R12 back to run", wake_pulse, 0);

        // R6 masked line ignored in wait, then break
        irq_en = 8'h00;
        strobe_wait();
        irq_req = 8'hFF; ticks(4);
        chk(!cpu_clk_en, "R6 masked irq ignored", cpu_clk_en, 0);
        irq_req = 0;
        brk_req = 1; tick(); brk_req = 0;
        chk(wake_pulse && !stack_go && reg_rdata[1], "R8 break wake flag", reg_rdata, 2);
        tick();
        reg_wr = 1; reg_wbit = 1; tick(); reg_wr = 0;
        chk(reg_rdata == 8'h02, "R10 write one no effect", reg_rdata, 2);
        reg_wr = 1; reg_wbit = 0; tick(); reg_wr = 0;
        chk(reg_rdata == 8'h00, "R10 write zero clears", reg_rdata, 0);

        // R7 stop: internal line ignored, external line wakes
        irq_en = 8'hFF;
        strobe_stop();
        chk(!per_clk_en && !wdog_en, "R11 stop wdog off", wdog_en, 0);
        irq_req = 8'h20; ticks(3);
        chk(!per_clk_en, "R7 internal irq ignored in stop", per_clk_en, 0);
        wait_req = 1; ticks(2); wait_req = 0;
        chk(!per_clk_en, "R12 strobe ignored in stop", per_clk_en, 0);
        irq_req = 8'h01; tick(); irq_req = 0;
        chk(wake_pulse && stack_go, "R7 external irq wakes stop", wake_pulse, 1);
        tick();

        // R3 stop wins over wait
        irq_en = 0;
        wait_req = 1; stop_req = 1; tick(); wait_req = 0; stop_req = 0;
        chk(!per_clk_en, "R3 stop priority", per_clk_en, 0);
        brk_req = 1; tick(); brk_req = 0;
        chk(wake_cause == 2'b10, "R8 break ends stop", wake_cause, 2);
        wait_req = 1; tick(); wait_req = 0;
        chk(cpu_clk_en && !wake_pulse, "R12 strobe ignored in wake", cpu_clk_en, 1);

        // Pending enabled interrupt at the wait strobe: immediate wake
        irq_en = 8'h10; irq_req = 8'h10;
        strobe_wait();
        chk(wake_pulse && stack_go && imask_clr, "R5 pending at entry", stack_go, 1);
        irq_req = 0; tick();

        // R9 break and interrupt in the same cycle; set wins over clear
        strobe_wait();
        chk(wdog_en, "R11 wdog on in wait", wdog_en, 1);
        irq_req = 8'h10; brk_req = 1; reg_wr = 1; reg_wbit = 0; tick();
        irq_req = 0; brk_req = 0; reg_wr = 0;
        chk(wake_cause == 2'b10 && !stack_go && reg_rdata[1], "R9 break priority", wake_cause, 2);
        tick();

        // wdog_dis and reset during wait
        wdog_dis = 1; irq_en = 0;
        strobe_wait();
        chk(!wdog_en, "R11 wdog disabled", wdog_en, 0);
        rst_n = 0; #1;
        chk(cpu_clk_en && reg_rdata == 0, "R1 reset ends wait", cpu_clk_en, 1);
        @(negedge clk); rst_n = 1;
        wdog_dis = 0;
        ticks(3);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule